// File: doc/BRIEF.md
# Accumulator and Carry Logic Unit

This block is the working register of a small 16-bit accumulator processor, together with its one-bit extend flip-flop and the adder-and-logic network that feeds both. Each clock cycle the control unit may raise one operation strobe. The block then updates the accumulator and the extend bit from one of these sources: the data register input, the 8-bit input character, or its own current contents. The available operations are AND, add with carry capture, load, character input, complement, circulate right or left through the extend bit, increment, clear, and the extend-bit clear and complement.

The block also drives four status flags from its registered state. Skip decisions elsewhere use them: accumulator positive, accumulator negative, accumulator zero and extend zero. The strobe vector is normally one-hot. If more than one strobe is raised, a fixed priority picks the lowest-numbered one. No strobe means the state holds.

The internal flow is a decode step followed by an execute step. The strobe vector is reduced to one named operation: AND, ADD, LOAD, INPUT, COMPLEMENT, CIRCULATE_RIGHT, CIRCULATE_LEFT, INCREMENT, CLEAR, CLEAR_E, TOGGLE_E, or IDLE when no strobe is raised. That operation selects the next state of the two registers, which load on the next rising edge.

Top module: `acc_carry_unit`

## Requirements
- R1: When strobe bit 1 (add) is the selected operation, the accumulator becomes (accumulator + data input) modulo 2^16 and the extend bit becomes the carry out of bit 15.
- R2: With strobe bit 0 (and) selected, the accumulator becomes the bitwise AND of the accumulator and the data input. With strobe bit 2 (load) selected, the accumulator becomes the data input.
- R3: With strobe bit 3 (input) selected, accumulator bits 7..0 take the input character and bits 15..8 are unchanged.
- R4: With strobe bit 5 (circulate right) selected, every accumulator bit moves one place toward bit 0. Bit 15 receives the old extend bit, and the extend bit receives the old bit 0.
- R5: With strobe bit 6 (circulate left) selected, every accumulator bit moves one place toward bit 15. Bit 0 receives the old extend bit, and the extend bit receives the old bit 15.
- R6: Strobe bit 8 clears the accumulator. Strobe bit 4 complements it. Strobe bit 7 adds one to it modulo 2^16.
- R7: Strobe bit 9 clears the extend bit and strobe bit 10 complements it; both leave the accumulator unchanged.
- R8: The status outputs follow the registered state. ac_pos is 1 when accumulator bit 15 is 0. ac_neg is 1 when bit 15 is 1. ac_zero is 1 when all accumulator bits are 0. e_zero is 1 when the extend bit is 0.
- R9: With no strobe raised, the accumulator and the extend bit hold their values.
- R10: If several strobes are raised in one cycle, only the one with the lowest bit index is performed.
- R11: An active-low reset clears the accumulator and the extend bit.
- R12: The extend bit is unchanged by and, load, input, clear, complement and increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_strobe | input | 11 | Operation strobes, bit index as in the requirements |
| dr_in | input | 16 | Data register value |
| inpr_in | input | 8 | Input character |
| ac_out | output | 16 | Accumulator |
| e_out | output | 1 | Extend bit |
| ac_pos | output | 1 | Accumulator bit 15 is clear |
| ac_neg | output | 1 | Accumulator bit 15 is set |
| ac_zero | output | 1 | Accumulator is zero |
| e_zero | output | 1 | Extend bit is clear |

## Verification
The bench targets the carry boundary where 0xFFFF plus 1 wraps to zero. A design that drops the carry leaves the extend bit at 0 there, and one that also carries on increment corrupts the extend bit. Circulates are checked with the extend bit set and cleared and with the end bits of the accumulator both 0 and 1. Wiring the circulate as a plain shift would show as a lost bit or a wrong extend value. The bench also drives the input character over a full upper byte, which catches a design that clears bits 15..8. Finally it raises several strobes at once to catch a reversed priority.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int NUM_OPS = 11;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND     = 4'd0,
        OP_ADD     = 4'd1,
        OP_LOAD    = 4'd2,
        OP_INPUT   = 4'd3,
        OP_COMPL   = 4'd4,
        OP_CIRC_R  = 4'd5,
        OP_CIRC_L  = 4'd6,
        OP_INCR    = 4'd7,
        OP_CLEAR   = 4'd8,
        OP_CLR_E   = 4'd9,
        OP_TOG_E   = 4'd10,
        OP_IDLE    = 4'd15
    } acc_op_e;
endpackage

// File: rtl/acc_op_priority.sv
module acc_op_priority
    import acc_pkg::*;
(
    input  logic [NUM_OPS-1:0] strobe,
    output acc_op_e            op_sel
);
    always_comb begin
        op_sel = OP_IDLE;
        for (int k = NUM_OPS - 1; k >= 0; k--) begin
            if (strobe[k]) begin
                op_sel = acc_op_e'(k[OP_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IN_W   = 8
) (
    input  acc_op_e           op_sel,
    input  logic [DATA_W-1:0] ac_cur,
    input  logic              e_cur,
    input  logic [DATA_W-1:0] dr_val,
    input  logic [IN_W-1:0]   inpr_val,
    output logic [DATA_W-1:0] ac_nxt,
    output logic              e_nxt
);
    localparam int SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] sum_full;
    logic [DATA_W-1:0] incr_val;

    assign sum_full = {1'b0, ac_cur} + {1'b0, dr_val};
    assign incr_val = ac_cur + {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        ac_nxt = ac_cur;
        e_nxt  = e_cur;
        unique case (op_sel)
            OP_AND:    ac_nxt = ac_cur & dr_val;
            OP_ADD: begin
                ac_nxt = sum_full[DATA_W-1:0];
                e_nxt  = sum_full[DATA_W];
            end
            OP_LOAD:   ac_nxt = dr_val;
            OP_INPUT:  ac_nxt = {ac_cur[DATA_W-1:IN_W], inpr_val};
            OP_COMPL:  ac_nxt = ~ac_cur;
            OP_CIRC_R: begin
                ac_nxt = {e_cur, ac_cur[DATA_W-1:1]};
                e_nxt  = ac_cur[0];
            end
            OP_CIRC_L: begin
                ac_nxt = {ac_cur[DATA_W-2:0], e_cur};
                e_nxt  = ac_cur[DATA_W-1];
            end
            OP_INCR:   ac_nxt = incr_val;
            OP_CLEAR:  ac_nxt = '0;
            OP_CLR_E:  e_nxt  = 1'b0;
            OP_TOG_E:  e_nxt  = ~e_cur;
            default: begin
                ac_nxt = ac_cur;
                e_nxt  = e_cur;
            end
        endcase
    end
endmodule

// File: rtl/acc_carry_unit.sv
module acc_carry_unit
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IN_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_OPS-1:0]  op_strobe,
    input  logic [DATA_W-1:0]   dr_in,
    input  logic [IN_W-1:0]     inpr_in,
    output logic [DATA_W-1:0]   ac_out,
    output logic                e_out,
    output logic                ac_pos,
    output logic                ac_neg,
    output logic                ac_zero,
    output logic                e_zero
);
    acc_op_e           op_sel;
    logic [DATA_W-1:0] ac_q, ac_d;
    logic              e_q, e_d;

    acc_op_priority u_prio (
        .strobe (op_strobe),
        .op_sel (op_sel)
    );

    acc_datapath #(.DATA_W(DATA_W), .IN_W(IN_W)) u_dp (
        .op_sel   (op_sel),
        .ac_cur   (ac_q),
        .e_cur    (e_q),
        .dr_val   (dr_in),
        .inpr_val (inpr_in),
        .ac_nxt   (ac_d),
        .e_nxt    (e_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else begin
            ac_q <= ac_d;
            e_q  <= e_d;
        end
    end

    always_comb begin
        ac_out  = ac_q;
        e_out   = e_q;
        ac_pos  = ~ac_q[DATA_W-1];
        ac_neg  = ac_q[DATA_W-1];
        ac_zero = (ac_q == '0);
        e_zero  = ~e_q;
    end

    assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe == NUM_OPS'(2)) |=>
            ({e_out, ac_out} == ({1'b0, $past(ac_out)} + {1'b0, $past(dr_in)})));

    assert_input_low_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe == NUM_OPS'(8)) |=>
            (ac_out[DATA_W-1:IN_W] == $past(ac_out[DATA_W-1:IN_W]) &&
             ac_out[IN_W-1:0] == $past(inpr_in)));

    assert_circ_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe == NUM_OPS'(32)) |=>
            (e_out == $past(ac_out[0]) && ac_out[DATA_W-1] == $past(e_out)));

    assert_circ_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe == NUM_OPS'(64)) |=>
            (e_out == $past(ac_out[DATA_W-1]) && ac_out[0] == $past(e_out)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe == '0) |=> ($stable(ac_out) && $stable(e_out)));

    assert_incr_keeps_e_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe == NUM_OPS'(128)) |=> $stable(e_out));

    assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe[0] && $countones(op_strobe) > 1) |=>
            (ac_out == ($past(ac_out) & $past(dr_in)) && $stable(e_out)));
endmodule

// File: tb/test_acc_carry_unit.sv
module test_acc_carry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] op_strobe = '0;
    logic [15:0] dr_in = '0;
    logic [7:0]  inpr_in = '0;
    logic [15:0] ac_out;
    logic        e_out, ac_pos, ac_neg, ac_zero, e_zero;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int m_ac = 0;
    int m_e = 0;

    always #5 clk = ~clk;

    acc_carry_unit i_acc_carry_unit (
        .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .dr_in(dr_in),
        .inpr_in(inpr_in), .ac_out(ac_out), .e_out(e_out), .ac_pos(ac_pos),
        .ac_neg(ac_neg), .ac_zero(ac_zero), .e_zero(e_zero)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string ac_req, string e_req);
        check(ac_req, "ac", int'(ac_out), m_ac);
        check(e_req, "e", int'(e_out), m_e);
        check("R8", "ac_pos", int'(ac_pos), ((m_ac >> 15) & 1) == 0 ? 1 : 0);
        check("R8", "ac_neg", int'(ac_neg), (m_ac >> 15) & 1);
        check("R8", "ac_zero", int'(ac_zero), m_ac == 0 ? 1 : 0);
        check("R8", "e_zero", int'(e_zero), m_e == 0 ? 1 : 0);
    endtask

    // drive one cycle after a falling edge, update the model, check at the next falling edge
    task automatic apply(logic [10:0] s, int d, int inp);
        int op = -1;
        int n = 0;
        string ta, te;
        op_strobe = s;
        dr_in = 16'(d);
        inpr_in = 8'(inp);
        for (int k = 10; k >= 0; k--) if (s[k]) op = k;
        for (int k = 0; k < 11; k++) if (s[k]) n++;
        case (op)
            0: begin m_ac = m_ac & d; ta = "R2"; te = "R12"; end
            1: begin
                m_ac = m_ac + (d & 16'hFFFF);
                m_e = (m_ac >> 16) & 1;
                m_ac = m_ac & 16'hFFFF;
                ta = "R1"; te = "R1";
            end
            2: begin m_ac = d & 16'hFFFF; ta = "R2"; te = "R12"; end
            3: begin m_ac = (m_ac & 16'hFF00) | (inp & 8'hFF); ta = "R3"; te = "R12"; end
            4: begin m_ac = (~m_ac) & 16'hFFFF; ta = "R6"; te = "R12"; end
            5: begin
                int nb = m_ac & 1;
                m_ac = (m_ac >> 1) | (m_e << 15);
                m_e = nb; ta = "R4"; te = "R4";
            end
            6: begin
                int nb = (m_ac >> 15) & 1;
                m_ac = ((m_ac << 1) & 16'hFFFF) | m_e;
                m_e = nb; ta = "R5"; te = "R5";
            end
            7: begin m_ac = (m_ac + 1) & 16'hFFFF; ta = "R6"; te = "R12"; end
            8: begin m_ac = 0; ta = "R6"; te = "R12"; end
            9: begin m_e = 0; ta = "R7"; te = "R7"; end
            10: begin m_e = 1 - m_e; ta = "R7"; te = "R7"; end
            default: begin ta = "R9"; te = "R9"; end
        endcase
        if (n > 1) begin ta = "R10"; te = "R10"; end
        @(negedge clk);
        check_all(ta, te);
    endtask

    function automatic logic [10:0] bitv(int k);
        return 11'(1) << k;
    endfunction

    initial begin
        #(20000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_all("R11", "R11");
        rst_n = 1'b1;
        apply(bitv(2), 16'hFFFF, 0);       // load
        apply(bitv(1), 16'h0001, 0);       // add wraps to zero, carry 1
        apply(bitv(7), 0, 0);              // increment leaves e at 1
        apply(bitv(5), 0, 0);              // circulate right with e=1
        apply(bitv(5), 0, 0);
        apply(bitv(6), 0, 0);              // circulate left
        apply(bitv(2), 16'h8001, 0);
        apply(bitv(6), 0, 0);
        apply(bitv(5), 0, 0);
        apply(bitv(2), 16'hA5C3, 0);
        apply(bitv(3), 0, 8'h3C);          // input keeps upper byte
        apply(bitv(0), 16'h0FF0, 0);
        apply(bitv(4), 0, 0);
        apply(bitv(9), 0, 0);
        apply(bitv(10), 0, 0);
        apply(bitv(10), 0, 0);
        apply(11'b0, 16'h1234, 8'h55);     // idle hold
        apply(bitv(8), 0, 0);
        apply(bitv(7), 0, 0);
        apply(11'b00110000101, 16'h00FF, 0); // priority: and wins
        apply(11'b11000000110, 16'h0003, 0); // priority: add wins
        apply(11'b10100100000, 0, 0);        // priority: circulate right wins
        rst_n = 1'b0;
        m_ac = 0; m_e = 0;
        @(negedge clk);
        check_all("R11", "R11");
        rst_n = 1'b1;
        for (int i = 0; i < 600; i++) begin
            int sel = $urandom_range(0, 9);
            logic [10:0] s;
            if (sel < 7) s = bitv($urandom_range(0, 10));
            else if (sel == 7) s = '0;
            else s = 11'($urandom);
            apply(s, int'($urandom & 32'hFFFF), int'($urandom & 32'hFF));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule